// File: doc/BRIEF.md
# Two-Clock Pointer Queue

This block is a first-in first-out queue with separate write and read clocks. Each side has its own reset and data bus, so a producer and a consumer running at unrelated rates can pass words through it. The words are held in a small memory array. A write counter addresses the array on the write side and a read counter addresses it on the read side.

Each side advances only its own counter. The other side's counter reaches it in Gray code through a chain of synchronizing flops clocked by the receiving side. The write side raises a full flag and the read side raises an empty flag. Both flags are computed from the local counter and the synchronized remote counter. A flag may therefore stay asserted for a few cycles after the other side has freed a slot or supplied a word. This is safe: the queue never overruns and never underruns.

Read data is registered. A word appears on the read data port at the read clock edge that accepts the read, and it holds until the next accepted read.

Top module: `xclk_queue`

## Requirements
- R1: While its reset is low at a rising edge, each side returns to its start state. After both resets, the empty flag is 1 and the full flag is 0.
- R2: A read is accepted at a read clock edge where the read enable is 1 and the empty flag is 0. At that edge the read data port takes the oldest unread word, so words leave in the order they were accepted.
- R3: With no reads, exactly 2**ADDR_W writes are accepted and the full flag then reads 1. A write while full is dropped: later reads never return its word.
- R4: A read while empty is dropped. The read data port keeps its previous value, and no word is lost.
- R5: The empty flag reads 0 only when at least one accepted word has not yet been read.
- R6: The number of accepted but unread words never exceeds 2**ADDR_W.
- R7: With both enables held at 0 for at least six cycles of each clock, full equals (stored words == 2**ADDR_W) and empty equals (stored words == 0).
- R8: Successive values of each Gray-coded counter differ in at most one bit. Order and contents stay correct across many wraps of both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write side clock |
| wrst_n | input | 1 | Write side synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to enqueue |
| wr_full | output | 1 | Queue full, write side view |
| rclk | input | 1 | Read side clock |
| rrst_n | input | 1 | Read side synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Most recently dequeued word |
| rd_empty | output | 1 | Queue empty, read side view |

## Verification
The hardest situation to reach is a flag edge that coincides with a counter crossing. Examples are a write arriving just as the last free slot is released, or a read issued while a fresh word is still in the synchronizer. The clocks run at unrelated periods, so the relative phase sweeps continuously. The stimulus alternates write-heavy phases, read-heavy phases and balanced random phases, so both flags toggle many times while the other side is active. Directed phases fill the queue past its capacity and read past empty, then let the flags settle and compare them with the bench's model of stored words.

// File: rtl/xq_pkg.sv
// Shared defaults for the two-clock queue.
// Assumes: the address width is at least 2 so that the full compare can split
// the two top counter bits from the rest.
package xq_pkg;
    localparam int unsigned XQ_DATA_W      = 8;
    localparam int unsigned XQ_ADDR_W      = 3;
    localparam int unsigned XQ_SYNC_STAGES = 2;
endpackage

// File: rtl/xq_sync.sv
// Multi-flop synchronizer for a Gray-coded counter.
// Assumes: at most one input bit changes per source clock cycle. Reset is
// synchronous, active low, in the destination domain.
module xq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the remote value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xq_wr_ctrl.sv
// Write side counter and full flag.
// Assumes: rgray_s is the read counter in Gray code, already synchronized
// into wclk. Full is pessimistic and may lag a read by the synchronizer depth.
module xq_wr_ctrl #(
    parameter int unsigned AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [AW:0] rgray_s,
    output logic        full,
    output logic        we,
    output logic [AW-1:0] addr,
    output logic [AW:0] gray
);
    localparam int unsigned PW = AW + 1;

    logic [AW:0] bin, bin_nxt, gray_nxt;

    // Accept a write only while slots remain.
    assign we       = en && !full;
    assign bin_nxt  = bin + PW'(we);
    assign gray_nxt = bin_nxt ^ (bin_nxt >> 1);
    assign addr     = bin[AW-1:0];

    // Full: Gray counters differ only in the top two bits.
    assign full = (gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});

    // Advance the binary and Gray copies of the write counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nxt;
            gray <= gray_nxt;
        end
    end
endmodule

// File: rtl/xq_rd_ctrl.sv
// Read side counter and empty flag.
// Assumes: wgray_s is the write counter in Gray code, already synchronized
// into rclk. Empty is pessimistic and may lag a write by the synchronizer depth.
module xq_rd_ctrl #(
    parameter int unsigned AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [AW:0] wgray_s,
    output logic        empty,
    output logic        re,
    output logic [AW-1:0] addr,
    output logic [AW:0] gray
);
    localparam int unsigned PW = AW + 1;

    logic [AW:0] bin, bin_nxt, gray_nxt;

    // Accept a read only while words remain.
    assign re       = en && !empty;
    assign bin_nxt  = bin + PW'(re);
    assign gray_nxt = bin_nxt ^ (bin_nxt >> 1);
    assign addr     = bin[AW-1:0];

    // Empty: both counters are identical, wrap bit included.
    assign empty = (gray == wgray_s);

    // Advance the binary and Gray copies of the read counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nxt;
            gray <= gray_nxt;
        end
    end
endmodule

// File: rtl/xq_mem.sv
// Storage array: write port on wclk, registered read port on rclk.
// Assumes: the controllers never write a slot that is being read, which
// holds because full and empty keep the two counters apart.
module xq_mem #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (we) arr[waddr] <= wdata;
    end

    // Present the dequeued word; hold it otherwise.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rdata <= '0;
        else if (re)  rdata <= arr[raddr];
    end
endmodule

// File: rtl/xclk_queue.sv
// Top of the two-clock queue: storage, both controllers and both
// synchronizers. Assumes ADDR_W >= 2 and resets held for at least
// SYNC_STAGES edges of their own clock.
module xclk_queue
    import xq_pkg::*;
#(
    parameter int unsigned DATA_W      = XQ_DATA_W,
    parameter int unsigned ADDR_W      = XQ_ADDR_W,
    parameter int unsigned SYNC_STAGES = XQ_SYNC_STAGES
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned PW = ADDR_W + 1;

    logic              we, re;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

    xq_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .en(wr_en), .rgray_s(rgray_s),
        .full(wr_full), .we(we), .addr(waddr), .gray(wgray)
    );

    xq_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .en(rd_en), .wgray_s(wgray_s),
        .empty(rd_empty), .re(re), .addr(raddr), .gray(rgray)
    );

    xq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    xq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    xq_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rrst_n(rrst_n), .re(re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/xq_checker.sv
// Property checker for the two-clock queue, bound to every instance.
module xq_checker #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          wr_en,
    input logic          wr_full,
    input logic [AW:0]   wgray,
    input logic          rclk,
    input logic          rrst_n,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   rgray
);
    AST_RST_EMPTY: assert property (@(posedge rclk) !rrst_n |=> rd_empty); // R1
    AST_RST_NOT_FULL: assert property (@(posedge wclk) !wrst_n |=> !wr_full); // R1
    AST_RD_ADVANCE: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && !rd_empty) |=> (rgray != $past(rgray))); // R2
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && wr_full) |=> $stable(wgray)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && rd_empty) |=> ($stable(rd_data) && $stable(rgray))); // R4
    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R8
    AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R8
endmodule

bind xclk_queue xq_checker #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_full(wr_full), .wgray(wgray),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_empty(rd_empty),
    .rd_data(rd_data), .rgray(rgray)
);

// File: tb/tb_xclk_queue.sv
`timescale 1ns/1ps
module tb_xclk_queue;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wrst_n = 1'b0, rrst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_full, rd_empty;

    int checks = 0, failures = 0, reads_done = 0;
    logic [DW-1:0] model [$];

    always #2.5 wclk = ~wclk;
    always #3.7 rclk = ~rclk;

    xclk_queue #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit coin(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    // Write side: drive at falling wclk; full is stable until the next rise.
    task automatic wr_loop(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            check("R6", 32'(model.size() <= DEPTH), 32'd1);
            wr_en   = coin(pct);
            wr_data = DW'($urandom);
            if (wr_en && !wr_full) model.push_back(wr_data);
        end
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    // Read side: check the previous read, then drive the next request.
    task automatic rd_loop(input int n, input int pct);
        bit pend = 0, hold = 0;
        logic [DW-1:0] exp = '0;
        for (int i = 0; i <= n; i++) begin
            @(negedge rclk);
            if (pend) begin check("R2", 32'(rd_data), 32'(exp)); reads_done++; end
            if (hold) check("R4", 32'(rd_data), 32'(exp));
            pend = 0; hold = 0;
            if (!rd_empty) check("R5", 32'(model.size() > 0), 32'd1);
            rd_en = (i < n) ? coin(pct) : 1'b0;
            if (rd_en && !rd_empty && model.size() > 0) begin
                exp = model.pop_front();
                pend = 1;
            end else if (rd_en && rd_empty) begin
                exp = rd_data;
                hold = 1;
            end
        end
        rd_en = 1'b0;
    endtask

    // Quiet period, then the flags must match the model exactly.
    task automatic settle_check();
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
        @(negedge wclk);
        check("R7 full", 32'(wr_full), 32'(model.size() == DEPTH));
        @(negedge rclk);
        check("R7 empty", 32'(rd_empty), 32'(model.size() == 0));
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int acc;
        void'($urandom(32'd1234));
        repeat (5) @(negedge wclk);
        repeat (5) @(negedge rclk);
        @(negedge wclk); wrst_n = 1'b1;
        @(negedge rclk); rrst_n = 1'b1;
        @(negedge rclk);
        check("R1 empty", 32'(rd_empty), 32'd1);
        @(negedge wclk);
        check("R1 full", 32'(wr_full), 32'd0);

        // R4: reads on an empty queue are dropped.
        rd_loop(4, 100);
        settle_check();

        // R3: fill beyond capacity with reads off.
        acc = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            @(negedge wclk);
            wr_en = 1'b1; wr_data = DW'(8'hA0 + i);
            if (!wr_full) begin model.push_back(wr_data); acc++; end
        end
        @(negedge wclk); wr_en = 1'b0;
        check("R3 accepted", 32'(acc), 32'(DEPTH));
        check("R3 full", 32'(wr_full), 32'd1);
        settle_check();
        // Drain: dropped words must not appear (R3), then read past empty (R4).
        rd_loop(DEPTH + 4, 100);
        settle_check();

        // Random phases with different balance; R8 wraps happen many times.
        fork wr_loop(800, 85); rd_loop(500, 30); join
        settle_check();
        fork wr_loop(600, 25); rd_loop(900, 90); join
        settle_check();
        fork wr_loop(1500, 60); rd_loop(1100, 75); join
        rd_loop(3 * DEPTH, 100);
        settle_check();
        check("R8 wraps", 32'(reads_done > 16 * DEPTH), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule